// File: doc/BRIEF.md
# Dual-Lane Byte FIFO with Burst Read

This block sits between a byte-wide bus engine and a 16-bit CPU/DMA port. Storage is two parallel byte FIFOs, one per byte lane. The CPU sees them together as a single word path: one 16-bit access pushes or pops both lanes at once. The bus engine moves single bytes, alternating between the upper lane and the lower lane.

Data flows in one direction at a time, chosen by `dir_rd`. With `dir_rd = 0` (write direction) the CPU pushes words and the engine drains bytes through a valid/ready egress stream. With `dir_rd = 1` (read direction) the engine fills bytes through a valid/ready ingress stream and the CPU pops words.

CPU accesses use active-low strobes and take effect on the strobe's rising (trailing) edge. A strobe counts only if the port was selected, by `cs_n` or by the DMA acknowledge `dack_n`, while the strobe was low. Burst-read mode keeps the head word on the data bus at all times. Each rising edge of the read strobe then moves the next word to the head. A burst-ready flag and a DMA request tell the CPU side when a transfer can go ahead.

Back-pressure on the engine side follows ordinary valid/ready rules. A byte moves in a cycle where both valid and ready are high at the clock edge. `eng_in_ready` depends only on the direction and on the fullness of the target lane, never on `eng_in_valid`. `eng_out_data` stays stable while `eng_out_valid` is high and no pop takes place.

Top module: `dlf_top`

## Requirements
- R1: In write direction a CPU word write stores bits [15:8] in the upper lane and bits [7:0] in the lower lane. The egress stream then emits the upper byte and then the lower byte of each word, in the order the words were written.
- R2: In read direction the first ingress byte goes to the upper lane and the next one to the lower lane, alternating from then on. A CPU word read returns {upper head, lower head}.
- R3: A CPU push or pop happens only on a rising edge of `wr_n` or `rd_n`, and only if `cs_n` or `dack_n` was low in the cycle before that edge. An unselected strobe changes no state.
- R4: While `burst_rd_n` is low, `cpu_rdata_oe` is high and the head word is driven on `cpu_rdata` with no strobe needed. Outside burst mode, `cpu_rdata_oe` is high only while `rd_n` is low with the port selected.
- R5: In burst mode each selected rising edge of `rd_n` removes exactly one word, and the next word appears on `cpu_rdata` one cycle after that edge is sampled.
- R6: Each lane holds 16 entries. A CPU write while either lane is full is dropped, sets `err_sticky`, and leaves the stored contents unchanged.
- R7: A CPU read in read direction with no full word present is dropped and sets `err_sticky`. `err_sticky` stays high until reset.
- R8: `fifo_rdy` is high in write direction when each lane has at least 8 free entries (16 bytes of space). In read direction it is high when at least one full word is present.
- R9: With `dma_en` high, `drq` is high in write direction while a word of space remains, and in read direction while a full word is present. It drops in the cycle the count reaches full or empty. With `dma_en` low, `drq` is low.
- R10: `eng_in_ready` is low in write direction and `eng_out_valid` is low in read direction. A CPU write in read direction, or a CPU read in write direction, is ignored and does not set `err_sticky`.
- R11: After reset the FIFO is empty, `err_sticky` and `drq` are low, and both lane toggles point at the upper lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_rd | input | 1 | 0 = write direction (CPU to engine), 1 = read direction (engine to CPU) |
| dma_en | input | 1 | Enables DMA request generation |
| cs_n | input | 1 | Active-low register-style select of the FIFO port |
| dack_n | input | 1 | Active-low DMA acknowledge; selects the FIFO port during a DMA cycle |
| wr_n | input | 1 | Active-low write strobe; push on its rising edge |
| rd_n | input | 1 | Active-low read strobe; pop on its rising edge |
| burst_rd_n | input | 1 | Active-low burst-read mode |
| cpu_wdata | input | 16 | Write word; latched while `wr_n` is low |
| cpu_rdata | output | 16 | Head word {upper, lower} |
| cpu_rdata_oe | output | 1 | High while the read word should be driven |
| fifo_rdy | output | 1 | Burst-ready flag |
| drq | output | 1 | DMA request |
| err_sticky | output | 1 | Sticky overflow/underflow flag |
| eng_in_valid | input | 1 | Ingress byte valid |
| eng_in_ready | output | 1 | Ingress byte ready |
| eng_in_data | input | 8 | Ingress byte |
| eng_out_valid | output | 1 | Egress byte valid |
| eng_out_ready | input | 1 | Egress byte ready |
| eng_out_data | output | 8 | Egress byte |

## Verification
A strobe's rising edge is seen at the first clock edge after the strobe goes high. The push or pop happens at that same edge, and `fifo_rdy`, `drq`, `err_sticky` and the head word all show the new count from that edge onward, with no added latency. Engine transfers take effect at the edge where valid and ready are both high. `cpu_rdata_oe` follows `burst_rd_n` and `rd_n` combinationally.

The bench drives every input on the falling edge. It samples results on the falling edge that follows the edge where the effect is due. That is one clock after the strobe is raised or the handshake completes, and the same half-cycle for output-enable checks.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } dlf_dir_e;

  typedef enum logic {
    LANE_HI = 1'b0,
    LANE_LO = 1'b1
  } dlf_lane_e;
endpackage

// File: rtl/dlf_lane_fifo.sv
module dlf_lane_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dlf_strobe.sv
module dlf_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  input  logic sel,
  output logic active,
  output logic fire
);
  logic strobe_q, sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      sel_q    <= 1'b0;
    end else begin
      strobe_q <= strobe_n;
      sel_q    <= sel;
    end
  end

  assign active = !strobe_n && sel;
  assign fire   = !strobe_q && strobe_n && sel_q;
endmodule

// File: rtl/dlf_flow.sv
module dlf_flow #(
  parameter int DEPTH       = 16,
  parameter int BURST_BYTES = 16,
  localparam int CW         = $clog2(DEPTH + 1),
  localparam int LANE_SPACE = BURST_BYTES / 2
) (
  input  logic          dir_rd,
  input  logic          dma_en,
  input  logic [CW-1:0] words,
  input  logic [CW-1:0] free,
  output logic          fifo_rdy,
  output logic          drq
);
  always_comb begin
    if (dir_rd) begin
      fifo_rdy = (words != '0);
      drq      = dma_en && (words != '0);
    end else begin
      fifo_rdy = (free >= CW'(LANE_SPACE));
      drq      = dma_en && (free != '0);
    end
  end
endmodule

// File: rtl/dlf_top.sv
module dlf_top #(
  parameter int LANE_W      = 8,
  parameter int DEPTH       = 16,
  parameter int BURST_BYTES = 16,
  localparam int CW         = $clog2(DEPTH + 1),
  localparam int NLANE      = 2,
  localparam int WORD_W     = LANE_W * NLANE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_rd,
  input  logic              dma_en,
  input  logic              cs_n,
  input  logic              dack_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              burst_rd_n,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic              fifo_rdy,
  output logic              drq,
  output logic              err_sticky,
  input  logic              eng_in_valid,
  output logic              eng_in_ready,
  input  logic [LANE_W-1:0] eng_in_data,
  output logic              eng_out_valid,
  input  logic              eng_out_ready,
  output logic [LANE_W-1:0] eng_out_data
);
  import dlf_pkg::*;

  dlf_dir_e    dir;
  assign dir = dlf_dir_e'(dir_rd);

  logic port_sel;
  logic wr_active, wr_fire, rd_active, rd_fire;
  assign port_sel = !cs_n || !dack_n;

  dlf_strobe u_wr_edge (.clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .sel(port_sel),
                        .active(wr_active), .fire(wr_fire));
  dlf_strobe u_rd_edge (.clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .sel(port_sel),
                        .active(rd_active), .fire(rd_fire));

  logic [WORD_W-1:0] wdat_q;
  always_ff @(posedge clk) begin
    if (!rst_n)     wdat_q <= '0;
    else if (!wr_n) wdat_q <= cpu_wdata;
  end

  // Per-lane signals; index 0 is the upper lane, 1 the lower lane.
  logic [LANE_W-1:0] l_din  [NLANE];
  logic [LANE_W-1:0] l_dout [NLANE];
  logic [CW-1:0]     l_cnt  [NLANE];
  logic [NLANE-1:0]  l_push, l_pop, l_full, l_empty;

  dlf_lane_e in_tog, out_tog;
  logic cpu_push_try, cpu_pop_try, cpu_push, cpu_pop;
  logic eng_push, eng_pop, space_ok, has_word;
  logic [CW-1:0] cnt_hi, cnt_lo, words, free;

  assign cnt_hi   = l_cnt[0];
  assign cnt_lo   = l_cnt[1];
  assign words    = (cnt_hi < cnt_lo) ? cnt_hi : cnt_lo;
  assign free     = CW'(DEPTH) - ((cnt_hi > cnt_lo) ? cnt_hi : cnt_lo);
  assign space_ok = (l_full == '0);
  assign has_word = (words != '0);

  assign cpu_push_try = wr_fire && (dir == DIR_WR);
  assign cpu_pop_try  = rd_fire && (dir == DIR_RD);
  assign cpu_push     = cpu_push_try && space_ok;
  assign cpu_pop      = cpu_pop_try && has_word;

  assign eng_in_ready  = (dir == DIR_RD) && !l_full[in_tog];
  assign eng_push      = eng_in_valid && eng_in_ready;
  assign eng_out_valid = (dir == DIR_WR) && !l_empty[out_tog];
  assign eng_out_data  = l_dout[out_tog];
  assign eng_pop       = eng_out_valid && eng_out_ready;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int HI_BIT = WORD_W - 1 - g * LANE_W;
    assign l_push[g] = cpu_push || (eng_push && (in_tog == dlf_lane_e'(g)));
    assign l_pop[g]  = cpu_pop  || (eng_pop  && (out_tog == dlf_lane_e'(g)));
    assign l_din[g]  = cpu_push ? wdat_q[HI_BIT -: LANE_W] : eng_in_data;
    assign cpu_rdata[HI_BIT -: LANE_W] = l_dout[g];

    dlf_lane_fifo #(.W(LANE_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(l_push[g]), .din(l_din[g]),
      .pop(l_pop[g]), .dout(l_dout[g]),
      .count(l_cnt[g]), .full(l_full[g]), .empty(l_empty[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_tog     <= LANE_HI;
      out_tog    <= LANE_HI;
      err_sticky <= 1'b0;
    end else begin
      if (eng_push) in_tog  <= (in_tog == LANE_HI) ? LANE_LO : LANE_HI;
      if (eng_pop)  out_tog <= (out_tog == LANE_HI) ? LANE_LO : LANE_HI;
      if ((cpu_push_try && !space_ok) || (cpu_pop_try && !has_word))
        err_sticky <= 1'b1;
    end
  end

  assign cpu_rdata_oe = !burst_rd_n || rd_active;

  dlf_flow #(.DEPTH(DEPTH), .BURST_BYTES(BURST_BYTES)) u_flow (
    .dir_rd(dir_rd), .dma_en(dma_en), .words(words), .free(free),
    .fifo_rdy(fifo_rdy), .drq(drq)
  );
endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dir_rd,
  input logic          dma_en,
  input logic          burst_rd_n,
  input logic          cpu_rdata_oe,
  input logic          fifo_rdy,
  input logic          drq,
  input logic          err_sticky,
  input logic          pop_try,
  input logic          has_word,
  input logic [CW-1:0] cnt_hi,
  input logic [CW-1:0] cnt_lo
);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hi <= CW'(DEPTH)) && (cnt_lo <= CW'(DEPTH)));

  // R7
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_try && !has_word) |=> err_sticky);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R9
  drq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rd && (cnt_hi == CW'(DEPTH) || cnt_lo == CW'(DEPTH))) |-> !drq);

  // R9
  drq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !drq);

  // R8
  rdy_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && (cnt_hi == '0 || cnt_lo == '0)) |-> !fifo_rdy);

  // R4
  burst_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_rd_n |-> cpu_rdata_oe);
endmodule

bind dlf_top dlf_checker #(.DEPTH(DEPTH)) u_dlf_checker (
  .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .dma_en(dma_en),
  .burst_rd_n(burst_rd_n), .cpu_rdata_oe(cpu_rdata_oe), .fifo_rdy(fifo_rdy),
  .drq(drq), .err_sticky(err_sticky), .pop_try(cpu_pop_try), .has_word(has_word),
  .cnt_hi(cnt_hi), .cnt_lo(cnt_lo)
);

// File: tb/tb_dlf_top.sv
`timescale 1ns/1ps
module tb_dlf_top;
  logic clk = 1'b0;
  logic rst_n;
  logic dir_rd, dma_en, cs_n, dack_n, wr_n, rd_n, burst_rd_n;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic cpu_rdata_oe, fifo_rdy, drq, err_sticky;
  logic eng_in_valid, eng_in_ready, eng_out_valid, eng_out_ready;
  logic [7:0] eng_in_data, eng_out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  dlf_top dut (
    .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd), .dma_en(dma_en),
    .cs_n(cs_n), .dack_n(dack_n), .wr_n(wr_n), .rd_n(rd_n),
    .burst_rd_n(burst_rd_n), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rdata_oe(cpu_rdata_oe), .fifo_rdy(fifo_rdy), .drq(drq),
    .err_sticky(err_sticky), .eng_in_valid(eng_in_valid),
    .eng_in_ready(eng_in_ready), .eng_in_data(eng_in_data),
    .eng_out_valid(eng_out_valid), .eng_out_ready(eng_out_ready),
    .eng_out_data(eng_out_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dir);
    @(negedge clk);
    rst_n = 1'b0; dir_rd = dir; dma_en = 1'b0; cs_n = 1'b1; dack_n = 1'b1;
    wr_n = 1'b1; rd_n = 1'b1; burst_rd_n = 1'b1; cpu_wdata = '0;
    eng_in_valid = 1'b0; eng_in_data = '0; eng_out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // mode: 0 unselected, 1 cs_n, 2 dack_n
  task automatic set_sel(input int mode, input logic on);
    cs_n   = !(on && mode == 1);
    dack_n = !(on && mode == 2);
  endtask

  task automatic cpu_write(input logic [15:0] w, input int mode);
    @(negedge clk);
    cpu_wdata = w; set_sel(mode, 1'b1); wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    set_sel(mode, 1'b0);
  endtask

  task automatic cpu_read(input int mode, output logic [15:0] w, output logic oe);
    @(negedge clk);
    set_sel(mode, 1'b1); rd_n = 1'b0;
    @(negedge clk);
    w = cpu_rdata; oe = cpu_rdata_oe;
    rd_n = 1'b1;
    @(negedge clk);
    set_sel(mode, 1'b0);
  endtask

  task automatic eng_push(input logic [7:0] b);
    @(negedge clk);
    check("R2 ingress ready", eng_in_ready, 1'b1);
    eng_in_valid = 1'b1; eng_in_data = b;
    @(negedge clk);
    eng_in_valid = 1'b0;
  endtask

  task automatic eng_pop_expect(input logic [7:0] b, input string req);
    @(negedge clk);
    check({req, " egress valid"}, eng_out_valid, 1'b1);
    check({req, " egress byte"}, eng_out_data, b);
    eng_out_ready = 1'b1;
    @(negedge clk);
    eng_out_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check("R11 err after reset", err_sticky, 1'b0);
    check("R11 drq after reset", drq, 1'b0);
    check("R11 egress empty", eng_out_valid, 1'b0);
    check("R11 rdy when empty (write dir)", fifo_rdy, 1'b1);
    check("R4 oe idle", cpu_rdata_oe, 1'b0);
  endtask

  task automatic t_write_egress();
    do_reset(1'b0);
    cpu_write(16'hA1B2, 1);
    cpu_write(16'hC3D4, 1);
    cpu_write(16'h0FF0, 2);
    eng_pop_expect(8'hA1, "R1");
    eng_pop_expect(8'hB2, "R1");
    eng_pop_expect(8'hC3, "R1");
    eng_pop_expect(8'hD4, "R1");
    eng_pop_expect(8'h0F, "R1");
    eng_pop_expect(8'hF0, "R1");
    @(negedge clk);
    check("R1 drained", eng_out_valid, 1'b0);
  endtask

  task automatic t_ingress_read();
    logic [15:0] w; logic oe;
    do_reset(1'b1);
    eng_push(8'h12); eng_push(8'h34); eng_push(8'h56); eng_push(8'h78);
    cpu_read(1, w, oe);
    check("R2 first word", w, 16'h1234);
    check("R4 oe during selected read", oe, 1'b1);
    cpu_read(2, w, oe);
    check("R2 second word", w, 16'h5678);
    check("R7 no error on valid reads", err_sticky, 1'b0);
  endtask

  task automatic t_unselected();
    logic [15:0] w; logic oe;
    do_reset(1'b0);
    cpu_write(16'h5555, 0);
    @(negedge clk);
    check("R3 unselected write ignored", eng_out_valid, 1'b0);
    do_reset(1'b1);
    eng_push(8'h9A); eng_push(8'hBC);
    cpu_read(0, w, oe);
    check("R4 oe low when unselected", oe, 1'b0);
    check("R3 unselected read keeps word", fifo_rdy, 1'b1);
    cpu_read(1, w, oe);
    check("R3 word still at head", w, 16'h9ABC);
  endtask

  task automatic t_burst();
    do_reset(1'b1);
    eng_push(8'h11); eng_push(8'h22); eng_push(8'h33);
    eng_push(8'h44); eng_push(8'h55); eng_push(8'h66);
    @(negedge clk);
    burst_rd_n = 1'b0; cs_n = 1'b0;
    @(negedge clk);
    check("R4 burst oe without strobe", cpu_rdata_oe, 1'b1);
    check("R4 burst head word", cpu_rdata, 16'h1122);
    rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    check("R5 next word after edge", cpu_rdata, 16'h3344);
    rd_n = 1'b0;
    @(negedge clk);
    check("R5 no pop while strobe low", cpu_rdata, 16'h3344);
    rd_n = 1'b1;
    @(negedge clk);
    check("R5 third word", cpu_rdata, 16'h5566);
    burst_rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    check("R4 oe off after burst", cpu_rdata_oe, 1'b0);
    check("R5 one word left", fifo_rdy, 1'b1);
  endtask

  task automatic t_full();
    do_reset(1'b0);
    dma_en = 1'b1;
    @(negedge clk);
    check("R9 drq with space", drq, 1'b1);
    for (int i = 0; i < 16; i++) begin
      cpu_write(16'h1000 + 16'(i), 2);
      if (i == 7)  check("R8 rdy with 8 free", fifo_rdy, 1'b1);
      if (i == 8)  check("R8 rdy drops at 7 free", fifo_rdy, 1'b0);
      if (i == 14) check("R9 drq one space left", drq, 1'b1);
    end
    check("R9 drq low when full", drq, 1'b0);
    check("R6 no error before overflow", err_sticky, 1'b0);
    cpu_write(16'hDEAD, 2);
    check("R6 overflow sets error", err_sticky, 1'b1);
    eng_pop_expect(8'h10, "R6");
    eng_pop_expect(8'h00, "R6");
    check("R9 drq back with space", drq, 1'b1);
    for (int i = 1; i < 16; i++) begin
      eng_pop_expect(8'h10, "R6");
      eng_pop_expect(8'(i), "R6");
    end
    @(negedge clk);
    check("R6 dropped word not stored", eng_out_valid, 1'b0);
  endtask

  task automatic t_empty();
    logic [15:0] w; logic oe;
    do_reset(1'b1);
    dma_en = 1'b1;
    @(negedge clk);
    check("R9 drq low when empty", drq, 1'b0);
    check("R8 rdy low when empty", fifo_rdy, 1'b0);
    eng_push(8'hA5);
    check("R9 drq low on half word", drq, 1'b0);
    eng_push(8'h5A);
    check("R9 drq with a word", drq, 1'b1);
    check("R8 rdy with a word", fifo_rdy, 1'b1);
    cpu_read(2, w, oe);
    check("R2 word via dack", w, 16'hA55A);
    check("R9 drq drops at empty", drq, 1'b0);
    check("R7 no error yet", err_sticky, 1'b0);
    cpu_read(1, w, oe);
    check("R7 underflow sets error", err_sticky, 1'b1);
    eng_push(8'h01); eng_push(8'h02);
    cpu_read(1, w, oe);
    check("R7 underflow did not move pointers", w, 16'h0102);
    check("R7 error sticky", err_sticky, 1'b1);
    dma_en = 1'b0;
    eng_push(8'h03); eng_push(8'h04);
    check("R9 drq off when disabled", drq, 1'b0);
  endtask

  task automatic t_direction();
    logic [15:0] w; logic oe;
    do_reset(1'b1);
    check("R10 ingress ready in read dir", eng_in_ready, 1'b1);
    check("R10 egress idle in read dir", eng_out_valid, 1'b0);
    cpu_write(16'h7777, 1);
    check("R10 write in read dir stores nothing", fifo_rdy, 1'b0);
    check("R10 write in read dir no error", err_sticky, 1'b0);
    do_reset(1'b0);
    check("R10 ingress blocked in write dir", eng_in_ready, 1'b0);
    cpu_write(16'h8899, 1);
    cpu_read(1, w, oe);
    check("R10 read in write dir no error", err_sticky, 1'b0);
    eng_pop_expect(8'h88, "R10");
  endtask

  initial begin
    t_reset();
    t_write_egress();
    t_ingress_read();
    t_unselected();
    t_burst();
    t_full();
    t_empty();
    t_direction();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule